// File: doc/BRIEF.md
# Scheduler Mode and Count Controller

This block is the control layer that sits around a task allocator and its processing stations. A two-bit mode selector picks one of four behaviours. In the quiescent mode every tally is cleared. In the run mode arriving tasks flow to the allocator. The single-station mode inhibits every station except the one selected. In the latency-programming mode a per-station, per-task-type cycle count is written into a table that the stations read.

Every cycle the block compares the number of tasks that arrived with the number of stations that reported a grant. From this it raises a registered overflow flag whenever some task was left unplaced. It also keeps a wrapping total of granted tasks and one wrapping tally for each station, and echoes the selected mode on two indicator outputs. The display driver consumes all of these values. Task codes are fields of `TYPE_W` bits, and the code 0 means "no task".

Top module: `sched_mode_ctrl`

## Requirements
- R1: `mode_ind` equals the value `mode` had at the previous rising clock edge.
- R2: In quiescent mode (`mode` = 00), `task_to_alloc` is all zero in the same cycle. At the next edge `total_cnt`, every field of `stn_cnt` and `flag_f` become 0.
- R3: In run mode (`mode` = 01), `task_to_alloc` equals `task_in` and `stn_inhibit` is all zero.
- R4: `flag_f` is registered. After an edge in run mode it is 1 exactly when the number of non-zero task fields exceeded the number of set `stn_grant` bits. After an edge in any other mode it is 0.
- R5: In single-station mode (`mode` = 10), `task_to_alloc` equals `task_in`. Bit i of `stn_inhibit` is 1 for every station i other than `dbg_stn`, and the bit for `dbg_stn` is 0.
- R6: In latency-programming mode (`mode` = 11), `task_to_alloc` is all zero and the counters hold their values whatever `stn_grant` shows. At each edge, `prg_cycles` is written into the latency entry addressed by station `prg_stn` and type `prg_type`.
- R7: A programming write with `prg_cycles` = 0 is discarded, and the addressed entry keeps its previous value.
- R8: `lat_rd_data` shows the entry addressed by `lat_rd_stn` and `lat_rd_type` as sampled at the previous edge, and entries of other addresses are not disturbed by a write.
- R9: In run and single-station modes, `total_cnt` adds the number of set `stn_grant` bits at each edge, modulo 2^CNT_W.
- R10: In run and single-station modes, station i's field `stn_cnt[i*CNT_W +: CNT_W]` adds `stn_grant[i]` at each edge, wrapping from 2^CNT_W-1 to 0.
- R11: A synchronous active-high `rst` clears `total_cnt`, `stn_cnt`, `flag_f` and `mode_ind`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scheduler clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 quiescent, 01 run, 10 single-station, 11 latency programming |
| task_in | input | NUM_TASK*TYPE_W | Arriving task codes, field k at bits k*TYPE_W; 0 means no task |
| dbg_stn | input | SEL_W | Station left live in single-station mode |
| prg_stn | input | SEL_W | Station addressed by a latency write |
| prg_type | input | TYPE_W | Task type addressed by a latency write |
| prg_cycles | input | LAT_W | Cycle count to store; 0 is discarded |
| stn_grant | input | NUM_STN | One bit per station: a task was placed on it this cycle |
| lat_rd_stn | input | SEL_W | Station of the latency read port |
| lat_rd_type | input | TYPE_W | Task type of the latency read port |
| task_to_alloc | output | NUM_TASK*TYPE_W | Mode-gated task codes for the allocator |
| stn_inhibit | output | NUM_STN | Per-station force-not-ready |
| lat_rd_data | output | LAT_W | Registered latency read data |
| mode_ind | output | 2 | Registered mode indicator |
| flag_f | output | 1 | Registered unplaced-task flag |
| total_cnt | output | CNT_W | Wrapping total of granted tasks |
| stn_cnt | output | NUM_STN*CNT_W | Wrapping per-station grant tallies |

## Verification
The bench builds the block with its defaults: two task inputs of three-bit codes, four stations, four-bit tallies and four-bit latencies. Four-bit tallies let a short run of four-grant cycles, or sixteen single-station grants, reach the wrap from 15 to 0. Four stations make the single-station inhibit pattern a distinct three-of-four mask. The three-bit type field gives the latency table 32 entries, enough to show that a write to one station leaves another station's entry untouched.

// File: rtl/sched_ctrl_pkg.sv
package sched_ctrl_pkg;
  typedef enum logic [1:0] {
    MODE_QUIET = 2'b00,
    MODE_RUN   = 2'b01,
    MODE_SOLO  = 2'b10,
    MODE_PROG  = 2'b11
  } sched_mode_e;
endpackage

// File: rtl/sched_mode_gate.sv
module sched_mode_gate
  import sched_ctrl_pkg::*;
#(
  parameter int NUM_TASK = 2,
  parameter int TYPE_W   = 3,
  parameter int NUM_STN  = 4,
  parameter int SEL_W    = 2
) (
  input  sched_mode_e                    mode,
  input  logic [NUM_TASK*TYPE_W-1:0]     task_in,
  input  logic [SEL_W-1:0]               dbg_stn,
  output logic [NUM_TASK*TYPE_W-1:0]     task_out,
  output logic [NUM_STN-1:0]             inhibit,
  output logic                           flow_en,
  output logic                           prog_en
);
  assign flow_en  = (mode == MODE_RUN) || (mode == MODE_SOLO);
  assign prog_en  = (mode == MODE_PROG);
  assign task_out = flow_en ? task_in : '0;

  for (genvar i = 0; i < NUM_STN; i++) begin : g_inh
    assign inhibit[i] = (mode == MODE_SOLO) && (dbg_stn != SEL_W'(i));
  end
endmodule

// File: rtl/sched_tally.sv
module sched_tally #(
  parameter int NUM_STN = 4,
  parameter int CNT_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clear,
  input  logic                       en,
  input  logic [NUM_STN-1:0]         grant,
  output logic [CNT_W-1:0]           total,
  output logic [NUM_STN*CNT_W-1:0]   per_stn
);
  localparam int PC_W = $clog2(NUM_STN + 1);

  logic [PC_W-1:0] grant_sum;

  always_comb begin
    grant_sum = '0;
    for (int i = 0; i < NUM_STN; i++) grant_sum = grant_sum + PC_W'(grant[i]);
  end

  always_ff @(posedge clk) begin
    if (rst || clear)  total <= '0;
    else if (en)       total <= total + CNT_W'(grant_sum);
  end

  for (genvar i = 0; i < NUM_STN; i++) begin : g_stn
    always_ff @(posedge clk) begin
      if (rst || clear)         per_stn[i*CNT_W +: CNT_W] <= '0;
      else if (en && grant[i])  per_stn[i*CNT_W +: CNT_W] <= per_stn[i*CNT_W +: CNT_W] + 1'b1;
    end
  end

  AST_TALLY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en && !clear) |=> $stable(total)); // R9
endmodule

// File: rtl/sched_lat_table.sv
module sched_lat_table #(
  parameter int SEL_W  = 2,
  parameter int TYPE_W = 3,
  parameter int LAT_W  = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_stn,
  input  logic [TYPE_W-1:0] wr_type,
  input  logic [LAT_W-1:0]  wr_data,
  input  logic [SEL_W-1:0]  rd_stn,
  input  logic [TYPE_W-1:0] rd_type,
  output logic [LAT_W-1:0]  rd_data
);
  localparam int ADDR_W = SEL_W + TYPE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [LAT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_stn, wr_type}] <= wr_data;
    rd_data <= mem[{rd_stn, rd_type}];
  end
endmodule

// File: rtl/sched_mode_ctrl.sv
module sched_mode_ctrl
  import sched_ctrl_pkg::*;
#(
  parameter int NUM_TASK = 2,
  parameter int TYPE_W   = 3,
  parameter int NUM_STN  = 4,
  parameter int CNT_W    = 4,
  parameter int LAT_W    = 4,
  localparam int SEL_W   = (NUM_STN > 1) ? $clog2(NUM_STN) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [1:0]                   mode,
  input  logic [NUM_TASK*TYPE_W-1:0]   task_in,
  input  logic [SEL_W-1:0]             dbg_stn,
  input  logic [SEL_W-1:0]             prg_stn,
  input  logic [TYPE_W-1:0]            prg_type,
  input  logic [LAT_W-1:0]             prg_cycles,
  input  logic [NUM_STN-1:0]           stn_grant,
  input  logic [SEL_W-1:0]             lat_rd_stn,
  input  logic [TYPE_W-1:0]            lat_rd_type,
  output logic [NUM_TASK*TYPE_W-1:0]   task_to_alloc,
  output logic [NUM_STN-1:0]           stn_inhibit,
  output logic [LAT_W-1:0]             lat_rd_data,
  output logic [1:0]                   mode_ind,
  output logic                         flag_f,
  output logic [CNT_W-1:0]             total_cnt,
  output logic [NUM_STN*CNT_W-1:0]     stn_cnt
);
  localparam int CMP_W = $clog2(NUM_TASK + NUM_STN + 1) + 1;

  sched_mode_e mode_e;
  logic        flow_en, prog_en, wr_ok;
  logic [CMP_W-1:0] arrive_n, grant_n;

  assign mode_e = sched_mode_e'(mode);

  sched_mode_gate #(.NUM_TASK(NUM_TASK), .TYPE_W(TYPE_W), .NUM_STN(NUM_STN), .SEL_W(SEL_W)) u_gate (
    .mode(mode_e), .task_in(task_in), .dbg_stn(dbg_stn),
    .task_out(task_to_alloc), .inhibit(stn_inhibit), .flow_en(flow_en), .prog_en(prog_en)
  );

  sched_tally #(.NUM_STN(NUM_STN), .CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst(rst), .clear(mode_e == MODE_QUIET), .en(flow_en),
    .grant(stn_grant), .total(total_cnt), .per_stn(stn_cnt)
  );

  assign wr_ok = prog_en && (prg_cycles != '0);

  sched_lat_table #(.SEL_W(SEL_W), .TYPE_W(TYPE_W), .LAT_W(LAT_W)) u_lat (
    .clk(clk), .wr_en(wr_ok), .wr_stn(prg_stn), .wr_type(prg_type), .wr_data(prg_cycles),
    .rd_stn(lat_rd_stn), .rd_type(lat_rd_type), .rd_data(lat_rd_data)
  );

  always_comb begin
    arrive_n = '0;
    for (int k = 0; k < NUM_TASK; k++)
      if (task_in[k*TYPE_W +: TYPE_W] != '0) arrive_n = arrive_n + CMP_W'(1);
    grant_n = '0;
    for (int i = 0; i < NUM_STN; i++) grant_n = grant_n + CMP_W'(stn_grant[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_ind <= 2'b00;
      flag_f   <= 1'b0;
    end else begin
      mode_ind <= mode;
      flag_f   <= (mode_e == MODE_RUN) && (arrive_n > grant_n);
    end
  end

  AST_MODE_ECHO: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (mode_ind == $past(mode))); // R1
  AST_QUIET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> (total_cnt == '0 && stn_cnt == '0 && !flag_f)); // R2
  AST_RUN_PASS: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |-> (task_to_alloc == task_in && stn_inhibit == '0)); // R3
  AST_FLAG_RUN_ONLY: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'b01) |=> !flag_f); // R4
  AST_SOLO_ONE_LIVE: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) |-> ($countones(stn_inhibit) == NUM_STN - 1)); // R5
  AST_PROG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11) |=> ($stable(total_cnt) && $stable(stn_cnt))); // R6
endmodule

// File: tb/sched_mode_ctrl_test.sv
module sched_mode_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 2, TW = 3, NS = 4, CW = 4, LW = 4, SW = 2;

  logic clk = 1'b0;
  logic rst;
  logic [1:0] mode;
  logic [NT*TW-1:0] task_in;
  logic [SW-1:0] dbg_stn, prg_stn, lat_rd_stn;
  logic [TW-1:0] prg_type, lat_rd_type;
  logic [LW-1:0] prg_cycles;
  logic [NS-1:0] stn_grant;
  logic [NT*TW-1:0] task_to_alloc;
  logic [NS-1:0] stn_inhibit;
  logic [LW-1:0] lat_rd_data;
  logic [1:0] mode_ind;
  logic flag_f;
  logic [CW-1:0] total_cnt;
  logic [NS*CW-1:0] stn_cnt;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [CW-1:0] exp_total;
  logic [CW-1:0] exp_stn [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  sched_mode_ctrl #(.NUM_TASK(NT), .TYPE_W(TW), .NUM_STN(NS), .CNT_W(CW), .LAT_W(LW)) uut (
    .clk(clk), .rst(rst), .mode(mode), .task_in(task_in), .dbg_stn(dbg_stn),
    .prg_stn(prg_stn), .prg_type(prg_type), .prg_cycles(prg_cycles), .stn_grant(stn_grant),
    .lat_rd_stn(lat_rd_stn), .lat_rd_type(lat_rd_type), .task_to_alloc(task_to_alloc),
    .stn_inhibit(stn_inhibit), .lat_rd_data(lat_rd_data), .mode_ind(mode_ind),
    .flag_f(flag_f), .total_cnt(total_cnt), .stn_cnt(stn_cnt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock: inputs already set at a falling edge; model follows the requirements
  task automatic step(input logic [NS-1:0] g);
    stn_grant = g;
    @(posedge clk);
    if (rst || mode == 2'b00) begin
      exp_total = '0;
      for (int i = 0; i < NS; i++) exp_stn[i] = '0;
    end else if (mode == 2'b01 || mode == 2'b10) begin
      for (int i = 0; i < NS; i++) begin
        exp_total = exp_total + CW'(g[i]);
        exp_stn[i] = exp_stn[i] + CW'(g[i]);
      end
    end
    @(negedge clk);
    stn_grant = '0;
  endtask

  task automatic check_counts(input string req);
    check(req, 32'(total_cnt), 32'(exp_total));
    for (int i = 0; i < NS; i++) check(req, 32'(stn_cnt[i*CW +: CW]), 32'(exp_stn[i]));
  endtask

  task automatic t_reset_state;
    check("R11 mode_ind", 32'(mode_ind), 0);
    check("R11 flag", 32'(flag_f), 0);
    check_counts("R11 counts");
    step('0);
    check("R1 mode_ind run", 32'(mode_ind), 1);
  endtask

  task automatic t_run_pass;
    mode = 2'b01; task_in = {3'd2, 3'd5}; #1;
    check("R3 tasks", 32'(task_to_alloc), 32'({3'd2, 3'd5}));
    check("R3 inhibit", 32'(stn_inhibit), 0);
    task_in = {3'd0, 3'd7}; #1;
    check("R3 tasks b", 32'(task_to_alloc), 32'({3'd0, 3'd7}));
  endtask

  task automatic t_flag;
    mode = 2'b01;
    task_in = {3'd2, 3'd1}; step(4'b0001);
    check("R4 two arrive one grant", 32'(flag_f), 1);
    step(4'b0110);
    check("R4 two arrive two grants", 32'(flag_f), 0);
    task_in = {3'd0, 3'd1}; step(4'b0000);
    check("R4 one arrive none granted", 32'(flag_f), 1);
    task_in = '0; step(4'b0000);
    check("R4 nothing arrives", 32'(flag_f), 0);
    check_counts("R9 after flag run");
  endtask

  task automatic t_wrap;
    mode = 2'b01; task_in = '0;
    for (int n = 0; n < 5; n++) begin
      step(4'b1111);
      check_counts("R9 total four grants");
    end
    for (int n = 0; n < 16; n++) step(4'b0001);
    check_counts("R10 station 0 wrap");
  endtask

  task automatic t_solo;
    mode = 2'b10; dbg_stn = 2'd2; task_in = {3'd1, 3'd2}; #1;
    check("R5 inhibit", 32'(stn_inhibit), 32'(4'b1011));
    check("R5 tasks pass", 32'(task_to_alloc), 32'({3'd1, 3'd2}));
    step(4'b0100);
    check("R4 flag low in solo", 32'(flag_f), 0);
    check("R1 mode_ind solo", 32'(mode_ind), 2);
    check_counts("R9 solo counts");
    dbg_stn = 2'd0; #1;
    check("R5 inhibit sel0", 32'(stn_inhibit), 32'(4'b1110));
  endtask

  task automatic t_program;
    logic [CW-1:0] hold;
    mode = 2'b11; task_in = {3'd3, 3'd1};
    prg_stn = 2'd1; prg_type = 3'd1; prg_cycles = 4'd3; #1;
    check("R6 tasks gated", 32'(task_to_alloc), 0);
    hold = total_cnt;
    step(4'b1111);
    check("R6 total holds", 32'(total_cnt), 32'(hold));
    check_counts("R6 counts hold");
    prg_stn = 2'd2; prg_type = 3'd1; prg_cycles = 4'd7;
    lat_rd_stn = 2'd1; lat_rd_type = 3'd1;
    step('0);
    check("R8 read entry 1/1", 32'(lat_rd_data), 3);
    prg_stn = 2'd1; prg_type = 3'd1; prg_cycles = 4'd0;
    step('0);
    check("R8 other station untouched", 32'(lat_rd_data), 3);
    lat_rd_stn = 2'd2;
    step('0);
    check("R7 zero discarded / R6 entry 2/1", 32'(lat_rd_data), 7);
    lat_rd_stn = 2'd1;
    step('0);
    check("R7 entry kept", 32'(lat_rd_data), 3);
    check("R1 mode_ind prog", 32'(mode_ind), 3);
  endtask

  task automatic t_quiet;
    mode = 2'b00; task_in = {3'd2, 3'd2}; #1;
    check("R2 tasks gated", 32'(task_to_alloc), 0);
    step(4'b1111);
    check("R2 flag", 32'(flag_f), 0);
    check_counts("R2 counts cleared");
    check("R2 total zero", 32'(total_cnt), 0);
  endtask

  task automatic t_sync_rst;
    mode = 2'b01; task_in = {3'd1, 3'd1};
    step(4'b0011); step(4'b0001);
    check_counts("R9 before rst");
    rst = 1'b1; step('0); rst = 1'b0;
    check_counts("R11 counts cleared");
    check("R11 total zero", 32'(total_cnt), 0);
    check("R11 mode_ind", 32'(mode_ind), 0);
    check("R11 flag", 32'(flag_f), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; mode = 2'b01; task_in = '0; dbg_stn = '0; prg_stn = '0; prg_type = '0;
    prg_cycles = '0; stn_grant = '0; lat_rd_stn = '0; lat_rd_type = '0;
    exp_total = '0;
    for (int i = 0; i < NS; i++) exp_stn[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_run_pass();
    t_flag();
    t_wrap();
    t_solo();
    t_program();
    t_quiet();
    t_sync_rst();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule